// File: doc/BRIEF.md
# Interrupt Event Combiner and Router

This block gathers 128 event lines and turns them into twelve interrupt requests, one for each core priority level from 4 to 15. Every event line has a sticky flag that a rising edge sets. The events form four groups of 32, and each group has a combiner. A combiner ORs the flags in its group that are set and not masked into one combined event. The four combined events take the event numbers 0 to 3, so the input lines with those numbers are never used.

A twelve-entry routing table picks the source of each priority output. An entry can name one of the combined events (0 to 3) or any single event from 4 to 127. When an entry routes a single event directly, that event drives the priority output from its flag alone. The event also drops out of its group's combiner. Software reaches the flags, masks and routing entries through a plain 4 KiB register window. The window has a write strobe and a read strobe. It never applies back-pressure: a write takes effect at the next clock edge, and read data appears exactly one cycle after the read strobe.

Register map (byte addresses, 32-bit words, address bits [1:0] must be zero):

| Offset | Content |
|---|---|
| 0x000 + 4*g | flags of group g (read-only); bit b is event 32*g+b |
| 0x010 + 4*g | clear for group g: a 1 clears that flag, reads return 0 |
| 0x020 + 4*g | mask for group g: a 1 blocks the event from the combiner |
| 0x040 + 4*i | routing entry i for priority 4+i: bit 7 enable, bits [6:0] event number |

Top module: `evt_router_top`

## Requirements
- R1: A 0-to-1 change on evt_in[n] (n >= 4) sets flag n at the next clock edge. An input held high does not set the flag again after a clear. The flag sets again only on a new rising edge.
- R2: Writing the clear word of group g clears each flag whose data bit is 1 and leaves the flags under 0 bits unchanged. If a rising edge and a clear hit the same flag in the same cycle, the flag ends up set.
- R3: Input lines 0 to 3 are ignored, and flag bits 0 to 3 of group 0 always read 0.
- R4: After reset every mask word reads 0xFFFFFFFF. Combined event g is 1 when a flag of group g is set, its mask bit is 0 and the event is not routed directly.
- R5: After reset, entries 8 to 11 read 0x80 to 0x83, so combiners 0 to 3 drive priorities 12 to 15, and entries 0 to 7 read 0. core_irq[i] is 0 whenever entry i has bit 7 clear.
- R6: An enabled entry i whose event number e is in the range 4 to 127 drives core_irq[i] with flag e.
- R7: An enabled entry whose event number is 0 to 3 drives core_irq[i] with the matching combined event. Two entries may name the same source.
- R8: A flag that an enabled entry routes directly does not reach its group's combiner. Once the entry is disabled, the event is combined again.
- R9: Read data is valid, with reg_rvalid high, in the cycle after reg_rd. Clear words, unmapped offsets and offsets whose bits [1:0] are not zero read 0. A routing entry reads back its 8 bits.
- R10: A directly routed event reaches its priority output whatever the state of its mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 128 | Event lines, synchronous to clk |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte address in the window |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid with reg_rvalid |
| reg_rvalid | output | 1 | High in the cycle after reg_rd |
| core_irq | output | 12 | Requests; bit i is core priority 4+i |

## Verification
The twelve outputs are combinational in the stored flags, masks and routing entries. A wrong flag, a lost mask bit or a stale direct-route exclusion therefore shows on core_irq in the same cycle the bad state appears, provided a routing entry selects the affected source. State that no entry currently selects stays hidden until a register read, which exposes it one cycle later. For this reason the directed tests read the flag, mask and route words back after each step as well as watching core_irq. They also change routing and masks while a flag is held, so that each exclusion path is made visible at the ports.

// File: rtl/evt_router_pkg.sv
package evt_router_pkg;
  localparam int NUM_GROUPS_DEF = 4;
  localparam int GROUP_W_DEF    = 32;
  localparam int NUM_PRIO_DEF   = 12;
  localparam int ADDR_W_DEF     = 12;
  localparam int DATA_W_DEF     = 32;

  // word offsets of the register regions inside the window
  localparam int FLAG_WORD  = 0;
  localparam int CLR_WORD   = 4;
  localparam int MASK_WORD  = 8;
  localparam int ROUTE_WORD = 16;
endpackage

// File: rtl/evt_flag_bank.sv
module evt_flag_bank #(
  parameter int GROUP_W = 32,
  parameter logic [GROUP_W-1:0] IGNORE = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [GROUP_W-1:0] evt_i,
  input  logic [GROUP_W-1:0] clr_i,
  output logic [GROUP_W-1:0] flag_o
);
  logic [GROUP_W-1:0] prev_q;
  logic [GROUP_W-1:0] flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      flag_q <= '0;
    end else begin
      prev_q <= evt_i;
      // a new edge wins over a clear in the same cycle
      flag_q <= ((flag_q & ~clr_i) | (evt_i & ~prev_q)) & ~IGNORE;
    end
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/evt_combiner.sv
module evt_combiner #(
  parameter int GROUP_W = 32
) (
  input  logic [GROUP_W-1:0] flag_i,
  input  logic [GROUP_W-1:0] mask_i,
  input  logic [GROUP_W-1:0] direct_i,
  output logic               comb_o
);
  assign comb_o = |(flag_i & ~mask_i & ~direct_i);
endmodule

// File: rtl/evt_route_table.sv
module evt_route_table #(
  parameter int NUM_PRIO   = 12,
  parameter int NUM_GROUPS = 4,
  parameter int NUM_EVT    = 128,
  localparam int IDX_W     = $clog2(NUM_EVT)
) (
  input  logic [NUM_PRIO-1:0]            route_en_i,
  input  logic [NUM_PRIO-1:0][IDX_W-1:0] route_idx_i,
  input  logic [NUM_EVT-1:0]             flag_i,
  input  logic [NUM_GROUPS-1:0]          comb_i,
  output logic [NUM_PRIO-1:0]            irq_o,
  output logic [NUM_EVT-1:0]             direct_o
);
  logic [NUM_EVT-1:0] src;

  // low event numbers stand for the combined events
  assign src = {flag_i[NUM_EVT-1:NUM_GROUPS], comb_i};

  always_comb begin
    direct_o = '0;
    for (int i = 0; i < NUM_PRIO; i++) begin
      irq_o[i] = route_en_i[i] & src[route_idx_i[i]];
      if (route_en_i[i] && (int'(route_idx_i[i]) >= NUM_GROUPS))
        direct_o[route_idx_i[i]] = 1'b1;
    end
  end
endmodule

// File: rtl/evt_router_top.sv
module evt_router_top
  import evt_router_pkg::*;
#(
  parameter int NUM_GROUPS = NUM_GROUPS_DEF,
  parameter int GROUP_W    = GROUP_W_DEF,
  parameter int NUM_PRIO   = NUM_PRIO_DEF,
  parameter int ADDR_W     = ADDR_W_DEF,
  parameter int DATA_W     = DATA_W_DEF,
  localparam int NUM_EVT   = NUM_GROUPS * GROUP_W,
  localparam int IDX_W     = $clog2(NUM_EVT),
  localparam int WORD_W    = ADDR_W - 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_EVT-1:0]  evt_in,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic                reg_rvalid,
  output logic [NUM_PRIO-1:0] core_irq
);
  logic [WORD_W-1:0]                word;
  logic                             aligned;
  logic [NUM_EVT-1:0]               flag_vec;
  logic [NUM_EVT-1:0]               direct_vec;
  logic [NUM_GROUPS-1:0]            comb_vec;
  logic [NUM_GROUPS-1:0][GROUP_W-1:0] mask_q;
  logic [NUM_PRIO-1:0]              route_en_q;
  logic [NUM_PRIO-1:0][IDX_W-1:0]   route_idx_q;
  logic [DATA_W-1:0]                rd_mux;

  assign word    = reg_addr[ADDR_W-1:2];
  assign aligned = (reg_addr[1:0] == 2'b00);

  // flag banks and combiners, one pair per group
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam logic [GROUP_W-1:0] IGN =
      (g == 0) ? GROUP_W'((1 << NUM_GROUPS) - 1) : '0;
    logic [GROUP_W-1:0] clr;

    assign clr = (reg_wr && aligned && word == WORD_W'(CLR_WORD + g))
               ? reg_wdata[GROUP_W-1:0] : '0;

    evt_flag_bank #(.GROUP_W(GROUP_W), .IGNORE(IGN)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_i (evt_in[g*GROUP_W +: GROUP_W]),
      .clr_i (clr),
      .flag_o(flag_vec[g*GROUP_W +: GROUP_W])
    );

    evt_combiner #(.GROUP_W(GROUP_W)) u_comb (
      .flag_i  (flag_vec[g*GROUP_W +: GROUP_W]),
      .mask_i  (mask_q[g]),
      .direct_i(direct_vec[g*GROUP_W +: GROUP_W]),
      .comb_o  (comb_vec[g])
    );
  end

  evt_route_table #(
    .NUM_PRIO  (NUM_PRIO),
    .NUM_GROUPS(NUM_GROUPS),
    .NUM_EVT   (NUM_EVT)
  ) u_route (
    .route_en_i (route_en_q),
    .route_idx_i(route_idx_q),
    .flag_i     (flag_vec),
    .comb_i     (comb_vec),
    .irq_o      (core_irq),
    .direct_o   (direct_vec)
  );

  // mask and routing registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int g = 0; g < NUM_GROUPS; g++) mask_q[g] <= '1;
      for (int i = 0; i < NUM_PRIO; i++) begin
        if (i >= NUM_PRIO - NUM_GROUPS) begin
          route_en_q[i]  <= 1'b1;
          route_idx_q[i] <= IDX_W'(i - (NUM_PRIO - NUM_GROUPS));
        end else begin
          route_en_q[i]  <= 1'b0;
          route_idx_q[i] <= '0;
        end
      end
    end else if (reg_wr && aligned) begin
      for (int g = 0; g < NUM_GROUPS; g++)
        if (word == WORD_W'(MASK_WORD + g)) mask_q[g] <= reg_wdata[GROUP_W-1:0];
      for (int i = 0; i < NUM_PRIO; i++)
        if (word == WORD_W'(ROUTE_WORD + i)) begin
          route_en_q[i]  <= reg_wdata[IDX_W];
          route_idx_q[i] <= reg_wdata[IDX_W-1:0];
        end
    end
  end

  // read path
  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (word == WORD_W'(FLAG_WORD + g)) rd_mux = DATA_W'(flag_vec[g*GROUP_W +: GROUP_W]);
        if (word == WORD_W'(MASK_WORD + g)) rd_mux = DATA_W'(mask_q[g]);
      end
      for (int i = 0; i < NUM_PRIO; i++)
        if (word == WORD_W'(ROUTE_WORD + i)) rd_mux = DATA_W'({route_en_q[i], route_idx_q[i]});
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      reg_rdata  <= reg_rd ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/evt_router_chk.sv
module evt_router_chk #(
  parameter int NUM_GROUPS = 4,
  parameter int NUM_EVT    = 128,
  parameter int NUM_PRIO   = 12
) (
  input logic                clk,
  input logic                rst_n,
  input logic [NUM_EVT-1:0]  evt_in,
  input logic [NUM_EVT-1:0]  flags,
  input logic [NUM_PRIO-1:0] route_en,
  input logic [NUM_PRIO-1:0] core_irq,
  input logic                reg_rd,
  input logic                reg_rvalid
);
  // R1: a flag only turns on when its input was high at that edge
  p_flag_needs_input_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~$past(flags) & ~$past(evt_in)) == '0));

  // R3: the numbers used by combined events never hold a flag
  p_low_flags_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[NUM_GROUPS-1:0] == '0));

  // R5: a disabled routing entry keeps its output low
  p_unrouted_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((core_irq & ~route_en) == '0));

  // R9: read data follows a read strobe by one cycle
  p_rvalid_after_rd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> reg_rvalid);

  // R9: no read data without a read strobe
  p_no_spurious_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> !reg_rvalid);
endmodule

bind evt_router_top evt_router_chk #(
  .NUM_GROUPS(NUM_GROUPS),
  .NUM_EVT   (NUM_EVT),
  .NUM_PRIO  (NUM_PRIO)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .evt_in    (evt_in),
  .flags     (flag_vec),
  .route_en  (route_en_q),
  .core_irq  (core_irq),
  .reg_rd    (reg_rd),
  .reg_rvalid(reg_rvalid)
);

// File: tb/evt_router_top_test.sv
module evt_router_top_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] evt_in = '0;
  logic         reg_wr = 1'b0;
  logic         reg_rd = 1'b0;
  logic [11:0]  reg_addr = '0;
  logic [31:0]  reg_wdata = '0;
  logic [31:0]  reg_rdata;
  logic         reg_rvalid;
  logic [11:0]  core_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  evt_router_top uut (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .reg_rvalid(reg_rvalid), .core_irq(core_irq)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    check("R9 rvalid", {31'b0, reg_rvalid}, 32'h1);
    d = reg_rdata;
  endtask

  task automatic pulse(input int n);
    @(negedge clk);
    evt_in[n] = 1'b1;
    @(negedge clk);
    evt_in[n] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R5 core_irq after reset", {20'b0, core_irq}, 32'h0);
    rd(12'h020, d); check("R4 mask0 reset", d, 32'hFFFFFFFF);
    rd(12'h02C, d); check("R4 mask3 reset", d, 32'hFFFFFFFF);
    rd(12'h060, d); check("R5 route8 reset", d, 32'h80);
    rd(12'h06C, d); check("R5 route11 reset", d, 32'h83);
    rd(12'h040, d); check("R5 route0 reset", d, 32'h0);
    rd(12'h000, d); check("R1 flag0 reset", d, 32'h0);
  endtask

  task automatic t_edge_and_mask();
    logic [31:0] d;
    @(negedge clk); evt_in[40] = 1'b1;
    @(negedge clk);
    rd(12'h004, d); check("R1 flag40 set on edge", d, 32'h100);
    check("R4 masked flag blocked", {20'b0, core_irq}, 32'h0);
    wr(12'h024, ~32'h100);
    check("R4 unmasked reaches prio 13", {20'b0, core_irq}, 32'h200);
    wr(12'h014, 32'h100);
    rd(12'h004, d); check("R1 held input no reset after clear", d, 32'h0);
    check("R2 clear drops combined", {20'b0, core_irq}, 32'h0);
    @(negedge clk); evt_in[40] = 1'b0;
    pulse(40);
    rd(12'h004, d); check("R1 new edge sets again", d, 32'h100);
    wr(12'h014, 32'hFFFFFFFF);
    wr(12'h024, 32'hFFFFFFFF);
  endtask

  task automatic t_low_inputs();
    logic [31:0] d;
    @(negedge clk); evt_in[3:0] = 4'hF;
    @(negedge clk); @(negedge clk);
    rd(12'h000, d); check("R3 inputs 0-3 ignored", d, 32'h0);
    wr(12'h020, 32'h0);
    check("R3 no combined from low inputs", {20'b0, core_irq}, 32'h0);
    wr(12'h020, 32'hFFFFFFFF);
    @(negedge clk); evt_in[3:0] = 4'h0;
  endtask

  task automatic t_clear();
    logic [31:0] d;
    pulse(5); pulse(6);
    rd(12'h000, d); check("R1 flags 5,6", d, 32'h60);
    wr(12'h010, 32'h20);
    rd(12'h000, d); check("R2 selective clear", d, 32'h40);
    @(negedge clk);
    evt_in[7] = 1'b1; reg_wr = 1'b1; reg_addr = 12'h010; reg_wdata = 32'h80;
    @(negedge clk);
    reg_wr = 1'b0; evt_in[7] = 1'b0;
    rd(12'h000, d); check("R2 set wins over clear", d, 32'hC0);
    rd(12'h010, d); check("R9 clear word reads 0", d, 32'h0);
    wr(12'h010, 32'hFFFFFFFF);
    rd(12'h000, d); check("R2 clear all", d, 32'h0);
  endtask

  task automatic t_direct();
    logic [31:0] d;
    wr(12'h050, 32'hA0);               // entry 4 -> event 32
    wr(12'h024, 32'hFFFFFFFE);         // unmask event 32 in group 1
    pulse(32);
    check("R6 R8 direct only, combiner excluded", {20'b0, core_irq}, 32'h010);
    wr(12'h024, 32'hFFFFFFFF);
    check("R10 mask ignored on direct", {20'b0, core_irq}, 32'h010);
    rd(12'h050, d); check("R9 route readback", d, 32'hA0);
    wr(12'h050, 32'h20);               // disable entry
    check("R5 disabled entry low", {20'b0, core_irq}, 32'h0);
    wr(12'h024, 32'hFFFFFFFE);
    check("R8 combined again after disable", {20'b0, core_irq}, 32'h200);
    wr(12'h014, 32'h1);
    wr(12'h024, 32'hFFFFFFFF);
    check("R2 cleanup", {20'b0, core_irq}, 32'h0);
  endtask

  task automatic t_combined_shared();
    wr(12'h040, 32'h82);               // entry 0 -> combiner 2
    wr(12'h028, ~32'h40);              // unmask event 70
    pulse(70);
    check("R7 combiner 2 on two entries", {20'b0, core_irq}, 32'h401);
    wr(12'h018, 32'h40);
    check("R7 both drop after clear", {20'b0, core_irq}, 32'h0);
    wr(12'h028, 32'hFFFFFFFF);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    rd(12'h800, d); check("R9 unmapped reads 0", d, 32'h0);
    rd(12'h022, d); check("R9 misaligned reads 0", d, 32'h0);
    rd(12'h044, d); check("R9 route1 reads 0", d, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_edge_and_mask();
    t_low_inputs();
    t_clear();
    t_direct();
    t_combined_shared();
    t_unmapped();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule